// File: doc/BRIEF.md
# Readout word pair to hit decoder

This block sits behind a receiver FIFO and consumes its 32-bit readout words one at a time over a valid/ready stream. Host timestamp words are recognised by their top byte and passed straight to a timestamp output. Each of the other words carries half of a 48-bit chip packet. A flag bit marks the upper or lower half, and a 3-bit field names the link the half came from. The block keeps one pending upper half per link and joins it with the next lower half from the same link. Halves from different links may therefore interleave freely.

A completed packet with a pixel-hit header is decoded into column x, row y, a binary time of arrival and the link number. Any other completed packet goes out unchanged on a second output, together with its header byte. Pairing faults are counted on an error counter. Each output holds one result until the consumer accepts it. Input is refused only while an output is stalled.

Top module: `hit_pair_decoder`

## Requirements
- R1: After reset, ts_valid, hit_valid and oth_valid are low, err_count is 0 and in_ready is high while all output readies are high.
- R2: An accepted word with bits 31:24 equal to 8'h51 is a timestamp. ts_valid rises in the cycle after acceptance, with ts_data equal to word bits 23:0. The timestamp word has no effect on pairing state.
- R3: A non-timestamp word gives its link in bits 27:25 and its payload in bits 23:0. With bit 24 clear it is stored as packet bits 47:24 for that link. With bit 24 set, and an upper half pending for that link, it completes the packet with bits 23:0. The result is presented in the cycle after acceptance. Links pair independently of each other.
- R4: A packet with bits 47:44 equal to 4'hB leaves on the hit output with hit_link set to its link. The fields are e = bits 43:37, s = bits 36:31 and p = bits 30:28, with r = 1 when p > 3. The output gives x = 4s + (p − 4r) and y = 2e + r.
- R5: hit_toa is packet bits 27:14 decoded from Gray code. The top binary bit equals the top Gray bit. Each lower binary bit is the binary bit above it XOR its own Gray bit.
- R6: Every completed packet whose bits 47:44 are not 4'hB leaves on the other output. oth_data carries all 48 packet bits, oth_header carries bits 47:40 and oth_link carries the link. Examples are headers 8'h71, 8'hF0 and 8'hE0.
- R7: An upper half that arrives while one is already pending for its link replaces it, and err_count increases by one.
- R8: A lower half that arrives with nothing pending for its link produces no output, and err_count increases by one.
- R9: An output whose valid is high and whose ready is low keeps its valid and data unchanged. While any output is stalled in this way, in_ready is low and input words are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input readout word |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| ts_valid | output | 1 | Timestamp output valid |
| ts_data | output | 24 | Timestamp payload, 25 ns per count |
| ts_ready | input | 1 | Timestamp consumer ready |
| hit_valid | output | 1 | Decoded hit valid |
| hit_x | output | 8 | Pixel column |
| hit_y | output | 8 | Pixel row |
| hit_toa | output | 14 | Binary time of arrival |
| hit_link | output | 3 | Link of the hit |
| hit_ready | input | 1 | Hit consumer ready |
| oth_valid | output | 1 | Other packet valid |
| oth_header | output | 8 | Header byte of the other packet |
| oth_data | output | 48 | Full other packet |
| oth_link | output | 3 | Link of the other packet |
| oth_ready | input | 1 | Other packet consumer ready |
| err_count | output | 16 | Count of pairing faults |

## Verification
A corrupted pending register or pending flag shows up on the next lower half from that link. The fault appears one cycle after that word is accepted, either as a wrong packet value, as a missing output, or as an unexpected step of err_count. Faults in field slicing or in the Gray decode appear on the hit output one cycle after the completing word, as a wrong x, y or ToA. A fault in the stall handling appears at once: in_ready stays high under a stalled output, or held data changes.

// File: rtl/hit_pair_decoder.sv
module hit_pair_decoder #(
  parameter int LINKS = 8,
  parameter int ERR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [31:0]      in_data,
  output logic             in_ready,
  output logic             ts_valid,
  output logic [23:0]      ts_data,
  input  logic             ts_ready,
  output logic             hit_valid,
  output logic [7:0]       hit_x,
  output logic [7:0]       hit_y,
  output logic [13:0]      hit_toa,
  output logic [2:0]       hit_link,
  input  logic             hit_ready,
  output logic             oth_valid,
  output logic [7:0]       oth_header,
  output logic [47:0]      oth_data,
  output logic [2:0]       oth_link,
  input  logic             oth_ready,
  output logic [ERR_W-1:0] err_count
);
  localparam int LW = (LINKS > 1) ? $clog2(LINKS) : 1;

  logic [23:0]      pend [LINKS];
  logic [LINKS-1:0] pend_v;
  logic [13:0]      toa_bin;

  wire          take      = in_valid & in_ready;
  wire          is_ts     = in_data[31:24] == 8'h51;
  wire          is_lower  = in_data[24];
  wire [LW-1:0] lnk       = in_data[25 +: LW];
  wire [47:0]   pkt       = {pend[lnk], in_data[23:0]};
  wire          is_hit    = pkt[47:44] == 4'hB;
  wire          chip_take = take & ~is_ts;
  wire          up_take   = chip_take & ~is_lower;
  wire          pair_done = chip_take & is_lower & pend_v[lnk];
  wire          pair_err  = chip_take & (is_lower ? ~pend_v[lnk] : pend_v[lnk]);
  wire [2:0]    pix       = pkt[30:28];
  wire          right     = pix > 3'd3;

  assign in_ready = ~((ts_valid & ~ts_ready) | (hit_valid & ~hit_ready) |
                      (oth_valid & ~oth_ready));

  always_comb begin
    toa_bin[13] = pkt[27];
    for (int i = 12; i >= 0; i--) toa_bin[i] = toa_bin[i+1] ^ pkt[14+i];
  end

  always_ff @(posedge clk) begin
    if (up_take) pend[lnk] <= in_data[23:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v    <= '0;
      err_count <= '0;
    end else begin
      if (up_take) pend_v[lnk] <= 1'b1;
      else if (pair_done) pend_v[lnk] <= 1'b0;
      if (pair_err) err_count <= err_count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts_valid <= 1'b0;
      ts_data  <= '0;
    end else if (take & is_ts) begin
      ts_valid <= 1'b1;
      ts_data  <= in_data[23:0];
    end else if (ts_ready) begin
      ts_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_valid <= 1'b0;
      hit_x     <= '0;
      hit_y     <= '0;
      hit_toa   <= '0;
      hit_link  <= '0;
    end else if (pair_done & is_hit) begin
      hit_valid <= 1'b1;
      hit_x     <= {pkt[36:31], 2'b00} + {5'd0, pix - {right, 2'b00}};
      hit_y     <= {pkt[43:37], right};
      hit_toa   <= toa_bin;
      hit_link  <= 3'(lnk);
    end else if (hit_ready) begin
      hit_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oth_valid  <= 1'b0;
      oth_header <= '0;
      oth_data   <= '0;
      oth_link   <= '0;
    end else if (pair_done & ~is_hit) begin
      oth_valid  <= 1'b1;
      oth_header <= pkt[47:40];
      oth_data   <= pkt;
      oth_link   <= 3'(lnk);
    end else if (oth_ready) begin
      oth_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/hit_pair_decoder_chk.sv
module hit_pair_decoder_chk #(
  parameter int ERR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [31:0]      in_data,
  input logic             in_ready,
  input logic             ts_valid,
  input logic [23:0]      ts_data,
  input logic             ts_ready,
  input logic             hit_valid,
  input logic [7:0]       hit_x,
  input logic [7:0]       hit_y,
  input logic [13:0]      hit_toa,
  input logic             hit_ready,
  input logic             oth_valid,
  input logic [47:0]      oth_data,
  input logic             oth_ready,
  input logic [ERR_W-1:0] err_count
);
  AST_TS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_data[31:24] == 8'h51) |=> (ts_valid && ts_data == $past(in_data[23:0]))); // R2
  AST_OTH_NOT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    oth_valid |-> oth_data[47:44] != 4'hB); // R6
  AST_ERR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (err_count == $past(err_count) || err_count == $past(err_count) + 1'b1)); // R7
  AST_TS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_valid && !ts_ready) |=> (ts_valid && $stable(ts_data))); // R9
  AST_HIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && !hit_ready) |=> (hit_valid && $stable(hit_x) && $stable(hit_y) && $stable(hit_toa))); // R9
  AST_OTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (oth_valid && !oth_ready) |=> (oth_valid && $stable(oth_data))); // R9
endmodule

bind hit_pair_decoder hit_pair_decoder_chk #(.ERR_W(ERR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
  .ts_valid(ts_valid), .ts_data(ts_data), .ts_ready(ts_ready),
  .hit_valid(hit_valid), .hit_x(hit_x), .hit_y(hit_y), .hit_toa(hit_toa), .hit_ready(hit_ready),
  .oth_valid(oth_valid), .oth_data(oth_data), .oth_ready(oth_ready), .err_count(err_count));

// File: tb/hit_pair_decoder_test.sv
module hit_pair_decoder_test;
  logic        clk = 0, rst_n = 0, in_valid = 0;
  logic [31:0] in_data = 0;
  logic        ts_ready = 1, hit_ready = 1, oth_ready = 1;
  logic        in_ready, ts_valid, hit_valid, oth_valid;
  logic [23:0] ts_data;
  logic [7:0]  hit_x, hit_y, oth_header;
  logic [13:0] hit_toa;
  logic [2:0]  hit_link, oth_link;
  logic [47:0] oth_data;
  logic [15:0] err_count;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  hit_pair_decoder uut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] half(input logic [2:0] l, input logic lo, input logic [23:0] d);
    return {4'h0, l, lo, d};
  endfunction

  function automatic logic [13:0] gray2bin(input logic [13:0] g);
    logic [13:0] b;
    b[13] = g[13];
    for (int i = 12; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [47:0] hitpkt(input int e, input int s, input int p, input logic [13:0] g);
    return {4'hB, 7'(e), 6'(s), 3'(p), g, 14'h0};
  endfunction

  task automatic send(input logic [31:0] w);
    in_valid = 1; in_data = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic send_pkt(input logic [2:0] l, input logic [47:0] p);
    send(half(l, 1'b0, p[47:24]));
    send(half(l, 1'b1, p[23:0]));
  endtask

  task automatic t_reset;
    check("R1 ts_valid", ts_valid, 0);
    check("R1 hit_valid", hit_valid, 0);
    check("R1 oth_valid", oth_valid, 0);
    check("R1 err_count", err_count, 0);
    check("R1 in_ready", in_ready, 1);
  endtask

  task automatic t_timestamp;
    send({8'h51, 24'hABCDEF});
    check("R2 ts_valid", ts_valid, 1);
    check("R2 ts_data", ts_data, 24'hABCDEF);
    check("R2 no hit", hit_valid, 0);
  endtask

  task automatic t_hit(input int e, input int s, input int p, input logic [13:0] g, input logic [2:0] l);
    int r = (p > 3) ? 1 : 0;
    send_pkt(l, hitpkt(e, s, p, g));
    check("R4 hit_valid", hit_valid, 1);
    check("R4 hit_x", hit_x, 64'(s * 4 + (p - 4 * r)));
    check("R4 hit_y", hit_y, 64'(e * 2 + r));
    check("R4 hit_link", hit_link, l);
    check("R5 hit_toa", hit_toa, gray2bin(g));
  endtask

  task automatic t_interleave;
    logic [47:0] a = hitpkt(3, 7, 1, 14'h0F0F), b = {8'h71, 40'h12_3456_789A};
    send(half(3'd2, 1'b0, a[47:24]));
    send(half(3'd5, 1'b0, b[47:24]));
    send({8'h51, 24'h000111});
    send(half(3'd2, 1'b1, a[23:0]));
    check("R3 first link hit", hit_valid, 1);
    check("R3 first link x", hit_x, 8'd29);
    check("R3 first link id", hit_link, 3'd2);
    send(half(3'd5, 1'b1, b[23:0]));
    check("R3 second link oth", oth_valid, 1);
    check("R3 second link data", oth_data, b);
    check("R3 err unchanged", err_count, 0);
  endtask

  task automatic t_other(input logic [47:0] p, input logic [2:0] l);
    send_pkt(l, p);
    check("R6 oth_valid", oth_valid, 1);
    check("R6 oth_header", oth_header, p[47:40]);
    check("R6 oth_data", oth_data, p);
    check("R6 oth_link", oth_link, l);
    check("R6 no hit", hit_valid, 0);
  endtask

  task automatic t_replace;
    logic [15:0] e0 = err_count;
    logic [47:0] p = {8'hE0, 40'hAA_BBCC_DDEE};
    send(half(3'd1, 1'b0, 24'h555555));
    send(half(3'd1, 1'b0, p[47:24]));
    check("R7 err step", err_count, e0 + 1);
    send(half(3'd1, 1'b1, p[23:0]));
    check("R7 newer upper used", oth_data, p);
  endtask

  task automatic t_orphan;
    logic [15:0] e0 = err_count;
    send(half(3'd3, 1'b1, 24'h123456));
    check("R8 no hit", hit_valid, 0);
    check("R8 no oth", oth_valid, 0);
    check("R8 err step", err_count, e0 + 1);
  endtask

  task automatic t_stall;
    logic [7:0] x0;
    hit_ready = 0;
    send_pkt(3'd4, hitpkt(9, 20, 5, 14'h1234));
    x0 = hit_x;
    check("R9 held valid", hit_valid, 1);
    check("R9 in_ready low", in_ready, 0);
    in_valid = 1; in_data = {8'h51, 24'h00BEEF};
    @(negedge clk); @(negedge clk);
    check("R9 input not taken", ts_valid, 0);
    check("R9 hit still valid", hit_valid, 1);
    check("R9 hit x stable", hit_x, x0);
    hit_ready = 1;
    @(negedge clk);
    in_valid = 0;
    check("R9 hit drained", hit_valid, 0);
    check("R9 ts taken after release", ts_data, 24'h00BEEF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_timestamp;
    t_hit(5, 10, 6, 14'h2A5F, 3'd0);
    t_hit(127, 63, 3, 14'h3FFF, 3'd7);
    t_hit(0, 0, 4, 14'h2000, 3'd6);
    t_interleave;
    t_other({8'h71, 40'h00_0000_0001}, 3'd3);
    t_other({8'hF0, 40'hFF_FFFF_FFFF}, 3'd0);
    t_replace;
    t_orphan;
    t_stall;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule